// File: doc/BRIEF.md
# Expansion Bus Master with Hold-Request Ownership

This block drives single read and write accesses onto an external multiplexed expansion bus on behalf of an on-chip requester. Before touching the bus it asks an external arbiter for ownership with an active-high hold-request output and waits for the active-high grant input. Only then does it drive the address with the active-low address-latch line, pulse the active-low read or write strobe for a fixed number of cycles, and give ownership back. Intel-style signalling is the only style supported.

The requester presents an address, a direction bit and, for writes, a data byte. It may do so whenever the ready output is high. Read data appears on a held output register. A one-cycle done pulse marks the end of every access. A parameter selects a variant for boards with no arbiter, where the grant input is tied high. In that variant the block neither waits for the grant to fall before accepting work nor after dropping its request.

Top module: `xbus_master`

## Requirements
- R1: While reset is asserted and directly after it, `eb_own_req` is 0, `eb_alat_n`, `eb_rstb_n` and `eb_wstb_n` are 1, `eb_doe` is 0, `done` is 0, `rd_data` is 0, and `req_ready` is 1 when `eb_own_gnt` is 0.
- R2: A request sampled with `req_valid` and `req_ready` both high raises `eb_own_req` in the next cycle. `eb_own_req` stays high through the cycle of the `done` pulse. Address and strobes stay inactive until `eb_own_gnt` is high.
- R3: Once the grant is seen, `eb_alat_n` is 0 for one address cycle plus the whole strobe window, a total of STROBE_CYC+1 cycles without a gap. It returns to 1 in the `done` cycle.
- R4: A read (`req_write`=0) holds `eb_rstb_n` low for exactly STROBE_CYC cycles right after the address cycle. Throughout the read, `eb_wstb_n` stays 1 and `eb_doe` stays 0.
- R5: A write (`req_write`=1) holds `eb_wstb_n` low for exactly STROBE_CYC cycles with `eb_rstb_n` at 1. `eb_doe` is 1 and `eb_dout` carries the write byte during both the address cycle and the strobe cycles. `eb_addr` carries the request address while `eb_alat_n` is 0, and reads 0 otherwise.
- R6: `rd_data` takes the value on `eb_din` at the last clock edge of the read strobe. `done` is high for exactly the one cycle after the strobe window. A write leaves `rd_data` unchanged.
- R7: In the cycle after `done`, `eb_own_req` falls. While `eb_own_gnt` stays high after that, `req_ready` is 0 and no new request is accepted.
- R8: Whenever `eb_own_gnt` is 0, the outputs `eb_alat_n`, `eb_rstb_n` and `eb_wstb_n` are 1, `eb_doe` is 0 and `eb_addr` is 0.
- R9: With GNT_TIED=1 and the grant tied high, a read shows `done` STROBE_CYC+3 cycles after acceptance. `req_ready` returns two cycles after `done` while the grant is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester offers an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write byte |
| req_ready | output | 1 | Block can take a request this cycle |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DW | Last byte read |
| eb_own_req | output | 1 | Bus ownership request, active high |
| eb_own_gnt | input | 1 | Bus ownership grant from arbiter, active high |
| eb_alat_n | output | 1 | Address latch, active low, held for the access |
| eb_rstb_n | output | 1 | Read strobe, active low |
| eb_wstb_n | output | 1 | Write strobe, active low |
| eb_addr | output | AW | Address lines, 0 when not driven |
| eb_dout | output | DW | Write data lines, 0 when not driven |
| eb_doe | output | 1 | Data output enable |
| eb_din | input | DW | Read data lines |

## Verification
The hardest case to reach from the ports is the release tail. The block has dropped its ownership request, but the arbiter still holds the grant high, and a new request is already waiting. The bench's behavioural arbiter has separate grant and release delays. With the release delay set long, the bench offers the next request in the very cycle after `done` and holds it there. It then checks that the request stays unaccepted until the grant falls. The read data source changes value on every strobe cycle, so only a capture on the last strobe edge gives the expected byte.

// File: rtl/ebm_pkg.sv
`timescale 1ns/1ps
package ebm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REQ  = 3'd1,
      ST_ADDR = 3'd2,
      ST_STRB = 3'd3,
      ST_END  = 3'd4,
      ST_REL  = 3'd5
   } ebm_state_e;

   // Ownership request is held from request through end of access
   function automatic logic owns_bus(ebm_state_e s);
      return (s == ST_REQ) || (s == ST_ADDR) || (s == ST_STRB) || (s == ST_END);
   endfunction

   // Address lines and latch are active in these states
   function automatic logic addr_phase(ebm_state_e s);
      return (s == ST_ADDR) || (s == ST_STRB);
   endfunction

endpackage

// File: rtl/ebm_seq.sv
`timescale 1ns/1ps
module ebm_seq
   import ebm_pkg::*;
#(
   parameter int STROBE_CYC = 3,
   parameter bit GNT_TIED   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       gnt,
   output ebm_state_e state,
   output logic       accept,
   output logic       last_strb,
   output logic       req_ready
);

   localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
   localparam logic [CW-1:0] CNT_LOAD = CW'(STROBE_CYC - 1);

   logic [CW-1:0] cnt;
   ebm_state_e    nxt;
   logic          bus_free;
   logic          release_ok;

   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("ebm_seq: STROBE_CYC must be at least 1");
   end

   // Variant: arbiter present, or grant tied high with no arbiter
   if (GNT_TIED) begin : g_tied
      assign bus_free   = 1'b1;
      assign release_ok = 1'b1;
   end else begin : g_arb
      assign bus_free   = ~gnt;
      assign release_ok = ~gnt;

      AST_NO_START_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
         (state == ST_IDLE && gnt) |=> (state == ST_IDLE)); // R7
   end

   assign req_ready = (state == ST_IDLE) && bus_free;
   assign accept    = req_ready && req_valid;
   assign last_strb = (state == ST_STRB) && (cnt == '0);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (accept)     nxt = ST_REQ;
         ST_REQ:  if (gnt)        nxt = ST_ADDR;
         ST_ADDR:                 nxt = ST_STRB;
         ST_STRB: if (cnt == '0)  nxt = ST_END;
         ST_END:                  nxt = ST_REL;
         ST_REL:  if (release_ok) nxt = ST_IDLE;
         default:                 nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         state <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (state == ST_ADDR) begin
         cnt <= CNT_LOAD;
      end else if (state == ST_STRB && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   AST_GRANT_BEFORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REQ && !gnt) |=> (state == ST_REQ)); // R2

endmodule

// File: rtl/ebm_regs.sv
`timescale 1ns/1ps
module ebm_regs #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          last_strb,
   input  logic [DW-1:0] din,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic          write_q,
   output logic [DW-1:0] rd_data
);

   logic capture;

   // Read byte is taken on the final strobe edge only
   assign capture = last_strb && !write_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         write_q <= req_write;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (capture) begin
         rd_data <= din;
      end
   end

   AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (last_strb && write_q) |=> $stable(rd_data)); // R6

endmodule

// File: rtl/ebm_pads.sv
`timescale 1ns/1ps
module ebm_pads
   import ebm_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  ebm_state_e    state,
   input  logic          gnt,
   input  logic          write_q,
   input  logic [AW-1:0] addr_q,
   input  logic [DW-1:0] wdata_q,
   output logic          own_req,
   output logic          alat_n,
   output logic          rstb_n,
   output logic          wstb_n,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] dout,
   output logic          doe
);

   logic drive;
   logic strobe;

   // Nothing reaches the bus pins unless ownership is granted
   assign drive   = gnt && addr_phase(state);
   assign strobe  = drive && (state == ST_STRB);

   assign own_req = owns_bus(state);
   assign alat_n  = ~drive;
   assign rstb_n  = ~(strobe && !write_q);
   assign wstb_n  = ~(strobe && write_q);
   assign doe     = drive && write_q;
   assign addr    = drive ? addr_q : '0;
   assign dout    = doe ? wdata_q : '0;

endmodule

// File: rtl/xbus_master.sv
`timescale 1ns/1ps
module xbus_master
   import ebm_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int STROBE_CYC = 3,
   parameter bit GNT_TIED   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic          eb_own_req,
   input  logic          eb_own_gnt,
   output logic          eb_alat_n,
   output logic          eb_rstb_n,
   output logic          eb_wstb_n,
   output logic [AW-1:0] eb_addr,
   output logic [DW-1:0] eb_dout,
   output logic          eb_doe,
   input  logic [DW-1:0] eb_din
);

   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("xbus_master: AW and DW must be positive");
   end

   ebm_state_e    state;
   logic          accept;
   logic          last_strb;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          write_q;

   ebm_seq #(
      .STROBE_CYC (STROBE_CYC),
      .GNT_TIED   (GNT_TIED)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .gnt        (eb_own_gnt),
      .state      (state),
      .accept     (accept),
      .last_strb  (last_strb),
      .req_ready  (req_ready)
   );

   ebm_regs #(
      .AW (AW),
      .DW (DW)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .last_strb  (last_strb),
      .din        (eb_din),
      .addr_q     (addr_q),
      .wdata_q    (wdata_q),
      .write_q    (write_q),
      .rd_data    (rd_data)
   );

   ebm_pads #(
      .AW (AW),
      .DW (DW)
   ) u_pads (
      .state      (state),
      .gnt        (eb_own_gnt),
      .write_q    (write_q),
      .addr_q     (addr_q),
      .wdata_q    (wdata_q),
      .own_req    (eb_own_req),
      .alat_n     (eb_alat_n),
      .rstb_n     (eb_rstb_n),
      .wstb_n     (eb_wstb_n),
      .addr       (eb_addr),
      .dout       (eb_dout),
      .doe        (eb_doe)
   );

   assign done = (state == ST_END);

   AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!eb_rstb_n && !eb_wstb_n)); // R4

   AST_STROBE_UNDER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!eb_rstb_n || !eb_wstb_n) |-> !eb_alat_n); // R3

   AST_LATCH_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !eb_alat_n |-> (eb_own_gnt && eb_own_req)); // R8

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_LATCH_RISE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eb_alat_n) && eb_own_gnt) |-> done); // R3

   AST_REQ_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eb_own_req) |-> $past(done)); // R7

endmodule

// File: tb/tb_xbus_master.sv
`timescale 1ns/1ps
module tb_xbus_master;

   localparam int AW = 16;
   localparam int DW = 8;
   localparam int N  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, done;
   logic [DW-1:0] rd_data;
   logic          eb_own_req;
   logic          eb_own_gnt = 1'b0;
   logic          eb_alat_n, eb_rstb_n, eb_wstb_n, eb_doe;
   logic [AW-1:0] eb_addr;
   logic [DW-1:0] eb_dout;
   logic [DW-1:0] eb_din = '0;

   // tied-grant instance
   logic          t_valid = 1'b0;
   logic [AW-1:0] t_addr = 16'h00C3;
   logic          t_ready, t_done, t_own_req, t_alat_n, t_rstb_n, t_wstb_n, t_doe;
   logic [DW-1:0] t_rd_data, t_dout;
   logic [AW-1:0] t_eb_addr;

   always #5 clk = ~clk;

   xbus_master #(.AW(AW), .DW(DW), .STROBE_CYC(N), .GNT_TIED(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .done(done), .rd_data(rd_data), .eb_own_req(eb_own_req),
      .eb_own_gnt(eb_own_gnt), .eb_alat_n(eb_alat_n), .eb_rstb_n(eb_rstb_n),
      .eb_wstb_n(eb_wstb_n), .eb_addr(eb_addr), .eb_dout(eb_dout),
      .eb_doe(eb_doe), .eb_din(eb_din));

   xbus_master #(.AW(AW), .DW(DW), .STROBE_CYC(N), .GNT_TIED(1'b1)) dut_tied (
      .clk(clk), .rst_n(rst_n), .req_valid(t_valid), .req_write(1'b0),
      .req_addr(t_addr), .req_wdata(8'h00), .req_ready(t_ready),
      .done(t_done), .rd_data(t_rd_data), .eb_own_req(t_own_req),
      .eb_own_gnt(1'b1), .eb_alat_n(t_alat_n), .eb_rstb_n(t_rstb_n),
      .eb_wstb_n(t_wstb_n), .eb_addr(t_eb_addr), .eb_dout(t_dout),
      .eb_doe(t_doe), .eb_din(8'h3C));

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int            m_st = 0;      // 0 idle,1 req,2 addr,3 strobe,4 end,5 release
   int            m_left = 0;
   bit            m_wr = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_wd = '0;
   logic [DW-1:0] m_rd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0;
         m_rd = '0;
      end else begin
         case (m_st)
            0: if (req_valid && !eb_own_gnt) begin
                  m_wr = req_write; m_addr = req_addr; m_wd = req_wdata; m_st = 1;
               end
            1: if (eb_own_gnt) m_st = 2;
            2: begin m_st = 3; m_left = N; end
            3: begin
                  m_left--;
                  if (m_left == 0) begin
                     if (!m_wr) m_rd = (m_addr[7:0] ^ 8'h5A) + 8'(N - 1);
                     m_st = 4;
                  end
               end
            4: m_st = 5;
            default: if (!eb_own_gnt) m_st = 0;
         endcase
      end
   end

   // ---------------- arbiter / read source and compare ----------------
   int gdly = 0, rdly = 0, acnt = 0, rcnt = 0;

   always @(negedge clk) begin
      bit            drv;
      logic [AW-1:0] e_addr;
      logic [DW-1:0] e_dout;
      drv    = eb_own_gnt && (m_st == 2 || m_st == 3);
      e_addr = drv ? m_addr : '0;
      e_dout = (drv && m_wr) ? m_wd : '0;
      chk(eb_own_req == (m_st >= 1 && m_st <= 4), "R2 own_req", eb_own_req, (m_st >= 1 && m_st <= 4));
      chk(eb_alat_n == !drv, "R3 alat_n", eb_alat_n, !drv);
      chk(eb_rstb_n == !(drv && m_st == 3 && !m_wr), "R4 rstb_n", eb_rstb_n, !(drv && m_st == 3 && !m_wr));
      chk(eb_wstb_n == !(drv && m_st == 3 && m_wr), "R5 wstb_n", eb_wstb_n, !(drv && m_st == 3 && m_wr));
      chk(eb_doe == (drv && m_wr), "R5 doe", eb_doe, (drv && m_wr));
      chk(eb_addr == e_addr, "R5 addr", eb_addr, e_addr);
      chk(eb_dout == e_dout, "R5 dout", eb_dout, e_dout);
      chk(done == (m_st == 4), "R6 done", done, (m_st == 4));
      chk(rd_data == m_rd, "R6 rd_data", rd_data, m_rd);
      chk(req_ready == (m_st == 0 && !eb_own_gnt), "R7 req_ready", req_ready, (m_st == 0 && !eb_own_gnt));
      if (!eb_own_gnt)
         chk(eb_alat_n && eb_rstb_n && eb_wstb_n && !eb_doe && eb_addr == '0,
             "R8 gated", {eb_alat_n, eb_rstb_n, eb_wstb_n, eb_doe}, 4'b1110);
      // arbiter
      if (eb_own_req && !eb_own_gnt) begin
         if (acnt >= gdly) begin eb_own_gnt = 1'b1; acnt = 0; end else acnt++;
      end else if (!eb_own_req && eb_own_gnt) begin
         if (acnt >= rdly) begin eb_own_gnt = 1'b0; acnt = 0; end else acnt++;
      end else begin
         acnt = 0;
      end
      // read data changes on every strobe cycle
      if (!eb_rstb_n) begin
         eb_din = (eb_addr[7:0] ^ 8'h5A) + 8'(rcnt);
         rcnt++;
      end else begin
         eb_din = 8'h00;
         rcnt = 0;
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int blocked);
      bit r;
      req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
      blocked = 0;
      forever begin
         r = req_ready;
         @(negedge clk); #1;
         if (r) break;
         blocked++;
      end
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      int guard = 0;
      while (!done && guard < 100) begin @(negedge clk); #1; guard++; end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      int blk;
      int n;
      repeat (3) @(negedge clk);
      #1;
      chk(!eb_own_req && eb_alat_n && eb_rstb_n && eb_wstb_n && !eb_doe && !done && rd_data == 0,
          "R1 reset outputs", {eb_own_req, eb_alat_n, eb_rstb_n, eb_wstb_n, eb_doe, done}, 6'b011100);
      chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!eb_own_req && t_ready && !t_own_req, "R1 after reset", {eb_own_req, t_ready, t_own_req}, 3'b010);

      // read, immediate grant
      gdly = 0; rdly = 0;
      issue(1'b0, 16'h1234, 8'h00, blk); wait_done();
      chk(rd_data == ((8'h34 ^ 8'h5A) + 8'(N - 1)), "R6 last-edge capture", rd_data, (8'h34 ^ 8'h5A) + 8'(N - 1));
      // write, slow grant
      gdly = 2; rdly = 1;
      issue(1'b1, 16'hBEEF, 8'hA7, blk); wait_done();
      chk(rd_data == ((8'h34 ^ 8'h5A) + 8'(N - 1)), "R6 write keeps rd_data", rd_data, (8'h34 ^ 8'h5A) + 8'(N - 1));
      // read, long grant wait (gated outputs while waiting)
      gdly = 4; rdly = 0;
      issue(1'b0, 16'h0F0F, 8'h00, blk); wait_done();

      // stale grant after release blocks the next request
      gdly = 1; rdly = 5;
      issue(1'b1, 16'h4321, 8'h5C, blk); wait_done();
      @(negedge clk); #1;
      chk(!eb_own_req && eb_own_gnt && !req_ready, "R7 stale grant", {eb_own_req, eb_own_gnt, req_ready}, 3'b010);
      issue(1'b0, 16'h7777, 8'h00, blk);
      chk(blk >= 1, "R7 request held off", blk, 1);
      wait_done();

      // mixed traffic
      for (int i = 0; i < 8; i++) begin
         gdly = i % 3; rdly = (i * 2) % 4;
         issue(i[0], 16'h1000 + 16'(i * 16'h0123), 8'(i * 37 + 5), blk);
         wait_done();
      end
      repeat (8) @(negedge clk);

      // tied-grant variant
      #1;
      chk(t_ready == 1'b1, "R9 tied ready", t_ready, 1);
      t_valid = 1'b1;
      n = 0;
      while (n < 50) begin
         @(negedge clk); #1; n++;
         if (n == 1) t_valid = 1'b0;
         if (t_done) break;
      end
      chk(n == N + 3, "R9 tied latency", n, N + 3);
      chk(t_rd_data == 8'h3C, "R9 tied rd_data", t_rd_data, 8'h3C);
      @(negedge clk); #1;
      chk(!t_own_req && !t_ready, "R9 tied release", {t_own_req, t_ready}, 2'b00);
      @(negedge clk); #1;
      chk(t_ready == 1'b1, "R9 tied ready again", t_ready, 1);

      repeat (4) @(negedge clk);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

endmodule